// File: doc/BRIEF.md
# Tree-Aware Next-Word Address Stepper

This block moves a cursor one word forward or one word back through an address space that is organised as a tree of page tables. The cursor is a path: for each table level it holds the real page of the table and the index used in it. Below the last table level it holds the real data page and a word offset inside that page. Most steps stay inside the current data page and only touch the word offset.

When the offset is already at the page edge, the block walks the tree. It climbs to the deepest level whose index can still move and steps that index. It drops every level below that one. It then walks back down through a synchronous memory read port, reading one table entry per descent step, until an entry names a data page.

A caller loads the current path with a one-cycle step pulse and a direction. While the walk runs, the block raises busy. It pulses done together with the new path and its real address. Every fault leaves the path exactly as it was loaded and reports a code. Bringing missing tables into memory is left to the caller.

Top module: `tree_stepper`

## Requirements
- R1: A step whose word offset is not at the edge of the page moves the offset by one. The edge is 255 when going up and 0 when going down. The step leaves the depth, table pages, indices and data page unchanged. It makes no memory read, and done rises in the second cycle after the step is sampled.
- R2: An upward step from offset 255 selects the deepest table level (level 0 is the root) whose index is not 255. It increments that index and discards all deeper levels before it descends.
- R3: After an upward climb, every table entry read on the way down is the one at index 0 of its table. The resulting word offset is 0.
- R4: A table entry is read at memory address {table real page, index}, with the page in the high byte. Data arrives one cycle after the request. Bit 15 of the entry is the resident flag and bit 14 is the data-page flag. Bits 7:0 are the real page number, and bits 13:8 are ignored.
- R5: If an entry read during descent has bit 15 clear, the step ends with fault code 2 and the path stays unchanged.
- R6: A downward step from offset 0 selects the deepest level whose index is not 0 and decrements it. On the way down it reads index 255 of every table, and the resulting word offset is 255.
- R7: If every loaded level is already at its edge index and the offset is at its edge, the step ends with fault code 1. No memory read is made and the path stays unchanged.
- R8: If the descent would need more than MAX_DEPTH table levels, the step ends with fault code 3 and the path stays unchanged.
- R9: busy is high from the cycle after the step is sampled until done. done is a one-cycle pulse that is never high together with busy. The address output equals {data page, word offset}, and a fault is flagged exactly when the code is non-zero.
- R10: A step pulse that arrives while a walk is running is ignored. Only one done is produced, and it carries the result of the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Step request, sampled when idle |
| dec_i | input | 1 | 1 = previous word, 0 = next word |
| depth_i | input | DEPTH_W | Number of table levels in the loaded path (1..MAX_DEPTH) |
| path_page_i | input | MAX_DEPTH*PAGE_W | Table real page per level, level k at bits k*PAGE_W |
| path_idx_i | input | MAX_DEPTH*IDX_W | Index per level, same packing |
| data_page_i | input | PAGE_W | Current data real page |
| word_i | input | WORD_W | Current word offset |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | PAGE_W+IDX_W | Entry address {page, index} |
| mem_data_i | input | ENTRY_W | Entry returned one cycle after the request |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid pulse |
| depth_o | output | DEPTH_W | Resulting number of table levels |
| path_page_o | output | MAX_DEPTH*PAGE_W | Resulting table pages |
| path_idx_o | output | MAX_DEPTH*IDX_W | Resulting indices |
| data_page_o | output | PAGE_W | Resulting data page |
| word_o | output | WORD_W | Resulting word offset |
| addr_o | output | PAGE_W+WORD_W | Real address {data page, word} |
| fault_o | output | 1 | Step faulted |
| fault_code_o | output | 2 | 0 none, 1 overflow, 2 not resident, 3 too deep |

## Verification
The assertions check the handshake on every cycle: the one-cycle done pulse, busy and done never overlapping, memory reads only during a walk, and a walk starting only on a step request. They also check, on every done, that a faulted result matches the loaded address and depth, and that an in-page step kept its data page and depth. Which entry is read on the way down, which level becomes the pivot, and the final indices all depend on tree contents. Only the bench's scenarios can show these, since each one preloads a small tree and predicts the walk.

// File: rtl/tree_step_pkg.sv
package tree_step_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLIMB,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } step_state_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_OVERFLOW = 2'd1,
    FLT_ABSENT   = 2'd2,
    FLT_DEPTH    = 2'd3
  } step_fault_e;
endpackage

// File: rtl/tree_step_pivot.sv
// Finds the deepest loaded level whose index is not at the edge for the direction.
module tree_step_pivot #(
  parameter int LEVELS  = 8,
  parameter int IDX_W   = 8,
  parameter int DEPTH_W = 4,
  parameter int LVL_W   = 3
) (
  input  logic [LEVELS*IDX_W-1:0] idx_i,
  input  logic [DEPTH_W-1:0]      depth_i,
  input  logic                    dec_i,
  output logic                    found_o,
  output logic [LVL_W-1:0]        level_o
);
  logic [LEVELS-1:0] cand;
  logic [IDX_W-1:0]  edge_idx;

  assign edge_idx = dec_i ? '0 : '1;

  for (genvar k = 0; k < LEVELS; k++) begin : g_cand
    assign cand[k] = (DEPTH_W'(k) < depth_i) && (idx_i[k*IDX_W +: IDX_W] != edge_idx);
  end

  always_comb begin
    found_o = 1'b0;
    level_o = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (cand[k]) begin
        found_o = 1'b1;
        level_o = LVL_W'(k);
      end
    end
  end
endmodule

// File: rtl/tree_step_entry_dec.sv
module tree_step_entry_dec #(
  parameter int ENTRY_W = 16,
  parameter int PAGE_W  = 8
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               resident_o,
  output logic               is_data_o,
  output logic [PAGE_W-1:0]  page_o
);
  logic unused_rsvd;

  assign resident_o  = entry_i[ENTRY_W-1];
  assign is_data_o   = entry_i[ENTRY_W-2];
  assign page_o      = entry_i[PAGE_W-1:0];
  // reserved / protection bits are carried but not interpreted
  assign unused_rsvd = ^entry_i[ENTRY_W-3:PAGE_W];
endmodule

// File: rtl/tree_stepper.sv
module tree_stepper
  import tree_step_pkg::*;
#(
  parameter int MAX_DEPTH = 8,
  parameter int PAGE_W    = 8,
  parameter int IDX_W     = 8,
  parameter int WORD_W    = 8,
  parameter int ENTRY_W   = 16,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          step_i,
  input  logic                          dec_i,
  input  logic [DEPTH_W-1:0]            depth_i,
  input  logic [MAX_DEPTH*PAGE_W-1:0]   path_page_i,
  input  logic [MAX_DEPTH*IDX_W-1:0]    path_idx_i,
  input  logic [PAGE_W-1:0]             data_page_i,
  input  logic [WORD_W-1:0]             word_i,
  output logic                          mem_req_o,
  output logic [PAGE_W+IDX_W-1:0]       mem_addr_o,
  input  logic [ENTRY_W-1:0]            mem_data_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [DEPTH_W-1:0]            depth_o,
  output logic [MAX_DEPTH*PAGE_W-1:0]   path_page_o,
  output logic [MAX_DEPTH*IDX_W-1:0]    path_idx_o,
  output logic [PAGE_W-1:0]             data_page_o,
  output logic [WORD_W-1:0]             word_o,
  output logic [PAGE_W+WORD_W-1:0]      addr_o,
  output logic                          fault_o,
  output logic [1:0]                    fault_code_o
);
  localparam int LVL_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

  step_state_e       st_q;
  logic              dec_q;
  logic [DEPTH_W-1:0] depth_q, o_depth;
  logic [PAGE_W-1:0] pg_q [MAX_DEPTH];
  logic [IDX_W-1:0]  ix_q [MAX_DEPTH];
  logic [PAGE_W-1:0] o_pg [MAX_DEPTH];
  logic [IDX_W-1:0]  o_ix [MAX_DEPTH];
  logic [PAGE_W-1:0] dp_q, o_dp;
  logic [WORD_W-1:0] wd_q, o_wd;
  step_fault_e       code_q;

  logic              piv_found;
  logic [LVL_W-1:0]  piv_lvl;
  logic [LVL_W-1:0]  cur_lvl;
  logic              ent_res, ent_data;
  logic [PAGE_W-1:0] ent_page;
  logic [WORD_W-1:0] word_edge;

  for (genvar k = 0; k < MAX_DEPTH; k++) begin : g_flat
    assign path_page_o[k*PAGE_W +: PAGE_W] = pg_q[k];
    assign path_idx_o[k*IDX_W +: IDX_W]    = ix_q[k];
  end

  tree_step_pivot #(
    .LEVELS (MAX_DEPTH),
    .IDX_W  (IDX_W),
    .DEPTH_W(DEPTH_W),
    .LVL_W  (LVL_W)
  ) u_pivot (
    .idx_i  (path_idx_o),
    .depth_i(depth_q),
    .dec_i  (dec_q),
    .found_o(piv_found),
    .level_o(piv_lvl)
  );

  tree_step_entry_dec #(
    .ENTRY_W(ENTRY_W),
    .PAGE_W (PAGE_W)
  ) u_dec (
    .entry_i   (mem_data_i),
    .resident_o(ent_res),
    .is_data_o (ent_data),
    .page_o    (ent_page)
  );

  assign word_edge  = dec_q ? '0 : '1;
  assign cur_lvl    = LVL_W'(depth_q - DEPTH_W'(1));
  assign mem_req_o  = (st_q == ST_READ);
  assign mem_addr_o = {pg_q[cur_lvl], ix_q[cur_lvl]};
  assign busy_o     = (st_q == ST_CLIMB) || (st_q == ST_READ) || (st_q == ST_WAIT);
  assign done_o     = (st_q == ST_DONE);
  assign depth_o    = depth_q;
  assign data_page_o = dp_q;
  assign word_o     = wd_q;
  assign addr_o     = {dp_q, wd_q};
  assign fault_o    = (code_q != FLT_NONE);
  assign fault_code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dec_q   <= 1'b0;
      depth_q <= '0;
      o_depth <= '0;
      dp_q    <= '0;
      o_dp    <= '0;
      wd_q    <= '0;
      o_wd    <= '0;
      code_q  <= FLT_NONE;
      for (int k = 0; k < MAX_DEPTH; k++) begin
        pg_q[k] <= '0;
        ix_q[k] <= '0;
        o_pg[k] <= '0;
        o_ix[k] <= '0;
      end
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (step_i) begin
            dec_q   <= dec_i;
            depth_q <= depth_i;
            o_depth <= depth_i;
            dp_q    <= data_page_i;
            o_dp    <= data_page_i;
            wd_q    <= word_i;
            o_wd    <= word_i;
            code_q  <= FLT_NONE;
            for (int k = 0; k < MAX_DEPTH; k++) begin
              pg_q[k] <= path_page_i[k*PAGE_W +: PAGE_W];
              o_pg[k] <= path_page_i[k*PAGE_W +: PAGE_W];
              ix_q[k] <= path_idx_i[k*IDX_W +: IDX_W];
              o_ix[k] <= path_idx_i[k*IDX_W +: IDX_W];
            end
            st_q <= ST_CLIMB;
          end
        end
        ST_CLIMB: begin
          if (wd_q != word_edge) begin
            wd_q <= dec_q ? wd_q - 1'b1 : wd_q + 1'b1;
            st_q <= ST_DONE;
          end else if (!piv_found) begin
            code_q <= FLT_OVERFLOW;
            st_q   <= ST_DONE;
          end else begin
            ix_q[piv_lvl] <= dec_q ? ix_q[piv_lvl] - 1'b1 : ix_q[piv_lvl] + 1'b1;
            depth_q       <= DEPTH_W'(piv_lvl) + DEPTH_W'(1);
            st_q          <= ST_READ;
          end
        end
        ST_READ: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (!ent_res || (!ent_data && depth_q == DEPTH_W'(MAX_DEPTH))) begin
            code_q  <= !ent_res ? FLT_ABSENT : FLT_DEPTH;
            depth_q <= o_depth;
            dp_q    <= o_dp;
            wd_q    <= o_wd;
            for (int k = 0; k < MAX_DEPTH; k++) begin
              pg_q[k] <= o_pg[k];
              ix_q[k] <= o_ix[k];
            end
            st_q <= ST_DONE;
          end else if (ent_data) begin
            dp_q <= ent_page;
            wd_q <= dec_q ? '1 : '0;
            st_q <= ST_DONE;
          end else begin
            pg_q[depth_q[LVL_W-1:0]] <= ent_page;
            ix_q[depth_q[LVL_W-1:0]] <= dec_q ? '1 : '0;
            depth_q <= depth_q + DEPTH_W'(1);
            st_q    <= ST_READ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R9
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(busy_o && done_o));
  // R9
  mem_req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o |-> busy_o);
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(step_i));
  // R5 R7 R8
  fault_keeps_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (addr_o == {o_dp, o_wd}) && (depth_o == o_depth));
  // R1
  inpage_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && o_wd != (dec_q ? '0 : '1)) |->
      (data_page_o == o_dp) && (depth_o == o_depth));
endmodule

// File: tb/sim_tree_stepper.sv
`timescale 1ns/1ps
module sim_tree_stepper;
  typedef struct {
    logic [3:0]      depth;
    logic [7:0][7:0] pg;
    logic [7:0][7:0] ix;
    logic [7:0]      dp;
    logic [7:0]      wd;
    logic [1:0]      code;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, dec = 1'b0;
  logic [3:0] in_depth = '0;
  logic [7:0][7:0] in_pg = '0, in_ix = '0;
  logic [7:0] in_dp = '0, in_wd = '0;
  logic mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic busy, done, fault;
  logic [3:0] out_depth;
  logic [63:0] out_pg, out_ix;
  logic [7:0] out_dp, out_wd;
  logic [15:0] out_addr;
  logic [1:0] out_code;

  logic [15:0] mem [int];
  int checks = 0, errors = 0, nreq = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  tree_stepper u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dec_i(dec), .depth_i(in_depth),
    .path_page_i(in_pg), .path_idx_i(in_ix), .data_page_i(in_dp), .word_i(in_wd),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_i(mem_rdata),
    .busy_o(busy), .done_o(done), .depth_o(out_depth), .path_page_o(out_pg),
    .path_idx_o(out_ix), .data_page_o(out_dp), .word_o(out_wd), .addr_o(out_addr),
    .fault_o(fault), .fault_code_o(out_code)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      nreq <= nreq + 1;
      mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
    end
  end

  task automatic chk(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", $sformatf("addr=%h", out_addr), "no done");
      end else begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (out_depth == e.depth) && (out_dp == e.dp) && (out_wd == e.wd) &&
             (out_code == e.code) && (fault == (e.code != 0)) &&
             (out_addr == {e.dp, e.wd});
        for (int k = 0; k < 8; k++)
          if (k < e.depth)
            ok = ok && (out_pg[k*8 +: 8] == e.pg[k]) && (out_ix[k*8 +: 8] == e.ix[k]);
        chk(ok, e.tag,
            $sformatf("d=%0d dp=%h wd=%h code=%0d pg=%h ix=%h", out_depth, out_dp, out_wd, out_code, out_pg, out_ix),
            $sformatf("d=%0d dp=%h wd=%h code=%0d pg=%h ix=%h", e.depth, e.dp, e.wd, e.code, e.pg, e.ix));
      end
    end
  end

  function automatic exp_t same(input string tag, input logic [1:0] code);
    exp_t e;
    e.depth = in_depth; e.pg = in_pg; e.ix = in_ix; e.dp = in_dp; e.wd = in_wd;
    e.code = code; e.tag = tag;
    return e;
  endfunction

  task automatic run(input bit d, input exp_t e, input bit inpage, input bit retrig);
    dec = d;
    step = 1'b1;
    q.push_back(e);
    @(negedge clk);
    step = retrig;
    dec = ~d;
    chk(busy && !done, "R9 busy after step", $sformatf("busy=%b done=%b", busy, done), "busy=1 done=0");
    @(negedge clk);
    step = 1'b0;
    if (inpage)
      chk(done && !busy && !mem_req, "R1 in-page latency", $sformatf("done=%b busy=%b", done, busy), "done=1 busy=0");
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [3:0] d, input logic [7:0] p0, input logic [7:0] i0,
                      input logic [7:0] p1, input logic [7:0] i1,
                      input logic [7:0] dp, input logic [7:0] wd);
    in_depth = d; in_pg = '0; in_ix = '0;
    in_pg[0] = p0; in_ix[0] = i0; in_pg[1] = p1; in_ix[1] = i1;
    in_dp = dp; in_wd = wd;
  endtask

  initial begin
    exp_t e;
    int n0;
    mem[{8'd2, 8'd11}]  = 16'hFD09;   // data, reserved bits set
    mem[{8'd1, 8'd4}]   = 16'h8014;
    mem[{8'd20, 8'd0}]  = 16'hC015;
    mem[{8'd2, 8'd9}]   = 16'hC00A;
    mem[{8'd1, 8'd2}]   = 16'h801E;
    mem[{8'd30, 8'd255}] = 16'hC01F;
    mem[{8'd1, 8'd51}]  = 16'h803C;
    mem[{8'd60, 8'd0}]  = 16'hC03D;
    mem[{8'd47, 8'd101}] = 16'h8032;
    mem[{8'd2, 8'd12}]  = 16'h4055;   // not resident
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !fault, "R9 reset state",
        $sformatf("busy=%b done=%b req=%b fault=%b", busy, done, mem_req, fault), "all 0");

    // R1 in-page up and down
    load(4'd2, 8'd1, 8'd3, 8'd2, 8'd10, 8'd5, 8'd7);
    e = same("R1 in-page inc", 2'd0); e.wd = 8'd8;
    run(1'b0, e, 1'b1, 1'b0);
    e = same("R1 in-page dec", 2'd0); e.wd = 8'd6;
    run(1'b1, e, 1'b1, 1'b0);

    // R10 retrigger while busy is ignored
    e = same("R10 step ignored while busy", 2'd0); e.wd = 8'd8;
    run(1'b0, e, 1'b1, 1'b1);

    // R2 R4 pivot at deepest level, reserved bits ignored
    load(4'd2, 8'd1, 8'd3, 8'd2, 8'd10, 8'd5, 8'd255);
    e = same("R2 R4 inc pivot deepest", 2'd0); e.ix[1] = 8'd11; e.dp = 8'h09; e.wd = 8'd0;
    run(1'b0, e, 1'b0, 1'b0);

    // R2 R3 climb to root, descend via entry 0
    load(4'd2, 8'd1, 8'd3, 8'd2, 8'd255, 8'd5, 8'd255);
    e = same("R2 R3 climb and descend 0", 2'd0);
    e.ix[0] = 8'd4; e.pg[1] = 8'd20; e.ix[1] = 8'd0; e.dp = 8'h15; e.wd = 8'd0;
    run(1'b0, e, 1'b0, 1'b0);

    // R3 descent adds a level
    load(4'd1, 8'd1, 8'd50, 8'd0, 8'd0, 8'd5, 8'd255);
    e = same("R3 descent deepens path", 2'd0);
    e.depth = 4'd2; e.ix[0] = 8'd51; e.pg[1] = 8'd60; e.ix[1] = 8'd0; e.dp = 8'h3D; e.wd = 8'd0;
    run(1'b0, e, 1'b0, 1'b0);

    // R6 decrement at deepest level
    load(4'd2, 8'd1, 8'd3, 8'd2, 8'd10, 8'd5, 8'd0);
    e = same("R6 dec pivot deepest", 2'd0); e.ix[1] = 8'd9; e.dp = 8'h0A; e.wd = 8'd255;
    run(1'b1, e, 1'b0, 1'b0);

    // R6 decrement climbs, descends via 255
    load(4'd2, 8'd1, 8'd3, 8'd2, 8'd0, 8'd5, 8'd0);
    e = same("R6 dec climb descend 255", 2'd0);
    e.ix[0] = 8'd2; e.pg[1] = 8'd30; e.ix[1] = 8'd255; e.dp = 8'h1F; e.wd = 8'd255;
    run(1'b1, e, 1'b0, 1'b0);

    // R5 non-resident entry
    load(4'd2, 8'd1, 8'd3, 8'd2, 8'd11, 8'd5, 8'd255);
    e = same("R5 non-resident fault", 2'd2);
    run(1'b0, e, 1'b0, 1'b0);

    // R7 overflow up and down, no memory read
    load(4'd2, 8'd1, 8'd255, 8'd2, 8'd255, 8'd5, 8'd255);
    n0 = nreq;
    e = same("R7 overflow inc", 2'd1);
    run(1'b0, e, 1'b0, 1'b0);
    load(4'd2, 8'd1, 8'd0, 8'd2, 8'd0, 8'd5, 8'd0);
    e = same("R7 overflow dec", 2'd1);
    run(1'b1, e, 1'b0, 1'b0);
    chk(nreq == n0, "R7 no memory read on overflow", $sformatf("%0d", nreq - n0), "0");

    // R8 depth limit
    in_depth = 4'd8;
    for (int k = 0; k < 8; k++) begin
      in_pg[k] = 8'(40 + k);
      in_ix[k] = 8'd5;
    end
    in_ix[7] = 8'd100; in_dp = 8'd77; in_wd = 8'd255;
    e = same("R8 depth fault", 2'd3);
    run(1'b0, e, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule